// File: doc/BRIEF.md
# BCD Time-of-Day Clock

This block keeps wall-clock time at a resolution of one tenth of a second. Time lives in four BCD registers: tenths, seconds, minutes and hours. Hours count 1 to 12, and a PM flag covers the whole day. A single-cycle `tick` input advances the clock. The tick comes from outside the block, for example from a divided reference. A carry ripples from the tenths up through the hours in the same cycle.

A CPU reaches the registers through a small register port. Reads are combinational on `addr`, and `rd_en` marks a read that has side effects. When the CPU reads the hours register, a coherent copy of all four registers is frozen. That copy is served until the tenths register is read, so a read of hours, then minutes, then seconds, then tenths returns one consistent instant while counting goes on underneath. When the CPU writes the hours register, the clock stops. Writing the tenths register starts it again, so the time can be set without a carry slipping in halfway.

Top module: `tod_clock`

## Requirements
- R1: After reset the time reads 12:00:00.0 AM: the tenths, seconds and minutes registers read 0x00 and the hours register reads 0x12.
- R2: A tick that is accepted advances tenths by one. When tenths is 9, the tick wraps it to 0 and advances seconds in the same cycle.
- R3: Seconds and minutes count 0x00 to 0x59 in BCD. From 0x59, a carry wraps the register to 0x00 and passes a carry up in the same cycle.
- R4: Hours count in BCD. A carry at hour 0x11 gives 0x12 and inverts the PM flag. A carry at 0x12 gives 0x01 and keeps the flag. Any other hour increments by one, so 0x09 becomes 0x10.
- R5: The read map is as follows. `addr` 0 is tenths in bits 3:0. `addr` 1 is seconds in bits 6:0. `addr` 2 is minutes in bits 6:0. `addr` 3 is hours in bits 4:0, with PM in bit 7 (1 = PM). All other bits read 0. Bits that a write supplies in those positions are discarded. `rd_data` follows `addr` combinationally.
- R6: An `rd_en` cycle at `addr` 3 freezes a copy of all four registers at that clock edge. `rd_data` then shows the frozen copy until an `rd_en` cycle at `addr` 0. That read still returns the frozen tenths, and the live values show from the next cycle on. Counting continues while the copy is frozen.
- R7: A write to `addr` 3 stops the clock, and ticks are then ignored. A write to `addr` 0 starts it again.
- R8: Writes to `addr` 1 and `addr` 2 load that register and do not change whether the clock is stopped.
- R9: A tick that arrives in the same cycle as any write is dropped.
- R10: While no copy is frozen, `rd_data` shows the live registers, including every tick accepted at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle tenth-of-second advance |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe with side effects (freeze or release the copy) |
| addr | input | 2 | Register select: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wr_data | input | 8 | Write data in BCD |
| rd_data | output | 8 | Read data in BCD |

## Verification
The block has only the package widths, so the bench builds it as-is: an 8-bit data path and a 2-bit register select. A full twelve-hour run would take hundreds of thousands of ticks. Instead, the bench uses the write path to set the time to x:59:59.9 just before the 11→12 and 12→1 hour changes, so both rollovers are reached in a few cycles. Random writes, reads and ticks are then mixed in. This makes freezes, halts and dropped ticks overlap with carries, and a bench-side time model predicts every read byte.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int NREG       = 4;
  localparam int NFIELD     = 3;          // tenths, seconds, minutes
  localparam int HOUR_W     = 5;
  localparam int TENTH_SEL  = 0;
  localparam int HOUR_SEL   = 3;
  localparam logic [HOUR_W-1:0] HOUR_RESET = 5'h12;

  // width of the stored BCD field for counter i
  function automatic int field_width(input int i);
    return (i == 0) ? 4 : 7;
  endfunction

  // last BCD value before wrap for counter i
  function automatic logic [7:0] field_max(input int i);
    return (i == 0) ? 8'h09 : 8'h59;
  endfunction

  // two-digit BCD increment
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 12-hour successor: {flip_pm, next_hour}
  function automatic logic [HOUR_W:0] hour_next(input logic [HOUR_W-1:0] h);
    if (h == 5'h12)      return {1'b0, 5'h01};
    else if (h == 5'h11) return {1'b1, 5'h12};
    else                 return {1'b0, HOUR_W'(bcd_inc(8'(h)))};
  endfunction
endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field #(
  parameter int         W   = 4,
  parameter logic [7:0] MAX = 8'h09
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] val,
  output logic         carry
);
  import tod_pkg::*;

  logic [W-1:0] nxt;
  logic         at_max;

  assign at_max = (val == MAX[W-1:0]);
  assign carry  = inc && at_max;
  assign nxt    = at_max ? '0 : W'(bcd_inc(8'(val)));

  always_ff @(posedge clk) begin
    if (!rst_n)    val <= '0;
    else if (load) val <= load_val;
    else if (inc)  val <= nxt;
  end

  // R3 / R2: a carry out leaves the field at zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    carry && !load |=> val == '0);
  // R2: an accepted increment below the limit changes the value
  p_step_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && !carry |=> val != $past(val));
  // R8: a load takes the supplied value
  p_load_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> val == $past(load_val));
endmodule

// File: rtl/tod_hours.sv
module tod_hours (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inc,
  input  logic                       load,
  input  logic [tod_pkg::HOUR_W-1:0] load_hr,
  input  logic                       load_pm,
  output logic [tod_pkg::HOUR_W-1:0] hr,
  output logic                       pm
);
  import tod_pkg::*;

  logic [HOUR_W:0] succ;
  assign succ = hour_next(hr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr <= HOUR_RESET;
      pm <= 1'b0;
    end else if (load) begin
      hr <= load_hr;
      pm <= load_pm;
    end else if (inc) begin
      hr <= succ[HOUR_W-1:0];
      pm <= pm ^ succ[HOUR_W];
    end
  end

  // R4: eleven to twelve inverts the PM flag
  p_noon_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && hr == 5'h11 |=> hr == 5'h12 && pm != $past(pm));
  // R4: twelve to one keeps the PM flag
  p_one_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && hr == 5'h12 |=> hr == 5'h01 && $stable(pm));
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          capture,
  input  logic                                          release_req,
  input  logic [tod_pkg::NREG-1:0][tod_pkg::DATA_W-1:0] live,
  output logic [tod_pkg::NREG-1:0][tod_pkg::DATA_W-1:0] snap,
  output logic                                          latched
);
  import tod_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched <= 1'b0;
      snap    <= '0;
    end else if (release_req) begin
      latched <= 1'b0;
    end else if (capture && !latched) begin
      latched <= 1'b1;
      snap    <= live;
    end
  end

  // R6: the frozen copy never moves while held
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latched && !release_req |=> $stable(snap) && latched);
  // R6: a capture request freezes the copy at the next edge
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    capture && !release_req && !latched |=> latched && snap == $past(live));
  // R6: reading tenths ends the freeze
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |=> !latched);
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic                           halted;
  logic                           step;       // accepted tick event
  logic [NFIELD:0]                inc_chain;  // carry ripple
  logic [NFIELD-1:0]              carry;
  logic                           hour_load;
  logic                           freeze_req;
  logic                           thaw_req;
  logic                           snap_latched;
  logic [HOUR_W-1:0]              hr;
  logic                           pm;
  logic [NREG-1:0][DATA_W-1:0]    live_word;
  logic [NREG-1:0][DATA_W-1:0]    snap_word;

  assign step         = tick && !halted && !wr_en;
  assign inc_chain[0] = step;
  assign hour_load    = wr_en && addr == ADDR_W'(HOUR_SEL);
  assign freeze_req   = rd_en && addr == ADDR_W'(HOUR_SEL);
  assign thaw_req     = rd_en && addr == ADDR_W'(TENTH_SEL);

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    localparam int W = field_width(i);
    logic [W-1:0] val;
    tod_bcd_field #(.W(W), .MAX(field_max(i))) u_field (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc_chain[i]),
      .load     (wr_en && addr == ADDR_W'(i)),
      .load_val (wr_data[W-1:0]),
      .val      (val),
      .carry    (carry[i])
    );
    assign inc_chain[i+1] = carry[i];
    assign live_word[i]   = DATA_W'(val);
  end

  tod_hours u_hours (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc_chain[NFIELD]),
    .load    (hour_load),
    .load_hr (wr_data[HOUR_W-1:0]),
    .load_pm (wr_data[DATA_W-1]),
    .hr      (hr),
    .pm      (pm)
  );
  assign live_word[HOUR_SEL] = {pm, {(DATA_W-HOUR_W-1){1'b0}}, hr};

  always_ff @(posedge clk) begin
    if (!rst_n)                                   halted <= 1'b0;
    else if (hour_load)                           halted <= 1'b1;
    else if (wr_en && addr == ADDR_W'(TENTH_SEL)) halted <= 1'b0;
  end

  tod_snapshot u_snap (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (freeze_req),
    .release_req (thaw_req),
    .live        (live_word),
    .snap        (snap_word),
    .latched     (snap_latched)
  );

  assign rd_data = snap_latched ? snap_word[addr] : live_word[addr];

  // R7: with the clock stopped and no write, the time does not move
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !wr_en |=> $stable(live_word));
  // R9: a write to a register other than tenths leaves tenths untouched
  p_tick_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr != ADDR_W'(TENTH_SEL) |=> $stable(live_word[TENTH_SEL]));
  // R8: a write to seconds or minutes keeps the run state
  p_mid_write_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == 2'd1 || addr == 2'd2) |=> $stable(halted));
  // R5: unused bits of every register stay zero
  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live_word[0][7:4] == 4'h0 && live_word[1][7] == 1'b0 &&
    live_word[2][7] == 1'b0 && live_word[3][6:5] == 2'b00);
endmodule

// File: tb/sim_tod_clock.sv
module sim_tod_clock;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench time model, binary
  int m_t, m_s, m_m, m_h; bit m_pm, m_halt, m_lat;
  int s_t, s_s, s_m, s_h; bit s_pm;

  always #(PERIOD/2) clk = ~clk;

  tod_clock u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] expect_word(input logic [1:0] a);
    int t, s, m, h; bit p;
    if (m_lat) begin t = s_t; s = s_s; m = s_m; h = s_h; p = s_pm; end
    else       begin t = m_t; s = m_s; m = m_m; h = m_h; p = m_pm; end
    case (a)
      2'd0: return to_bcd(t);
      2'd1: return to_bcd(s);
      2'd2: return to_bcd(m);
      default: return {p, 2'b00, to_bcd(h)[4:0]};
    endcase
  endfunction

  task automatic model_edge(input bit tk, input bit wr, input bit rd,
                            input logic [1:0] a, input logic [7:0] wd);
    if (rd && a == 2'd0) m_lat = 0;
    else if (rd && a == 2'd3 && !m_lat) begin
      m_lat = 1; s_t = m_t; s_s = m_s; s_m = m_m; s_h = m_h; s_pm = m_pm;
    end
    if (wr) begin
      case (a)
        2'd0: begin m_t = from_bcd({4'h0, wd[3:0]}); m_halt = 0; end
        2'd1: m_s = from_bcd(wd & 8'h7F);
        2'd2: m_m = from_bcd(wd & 8'h7F);
        default: begin m_h = from_bcd({3'b000, wd[4:0]}); m_pm = wd[7]; m_halt = 1; end
      endcase
    end else if (tk && !m_halt) begin
      m_t++;
      if (m_t == 10) begin
        m_t = 0; m_s++;
        if (m_s == 60) begin
          m_s = 0; m_m++;
          if (m_m == 60) begin
            m_m = 0;
            if (m_h == 12) m_h = 1;
            else if (m_h == 11) begin m_h = 12; m_pm = !m_pm; end
            else m_h++;
          end
        end
      end
    end
  endtask

  // one cycle: drive, compare the combinational read, clock, update model
  task automatic cyc(input bit tk, input bit wr, input bit rd, input logic [1:0] a,
                     input logic [7:0] wd, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    tick = tk; wr_en = wr; rd_en = rd; addr = a; wr_data = wd;
    #1;
    exp = expect_word(a);
    n_vec++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rd_data, exp);
    end
    @(posedge clk);
    model_edge(tk, wr, rd, a, wd);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m,
                          input logic [7:0] s, input logic [7:0] t, input string tag);
    cyc(0, 1, 0, 2'd3, h, tag);
    cyc(0, 1, 0, 2'd2, m, tag);
    cyc(0, 1, 0, 2'd1, s, tag);
    cyc(0, 1, 0, 2'd0, t, tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_t = 0; m_s = 0; m_m = 0; m_h = 12; m_pm = 0; m_halt = 0; m_lat = 0;
    s_t = 0; s_s = 0; s_m = 0; s_h = 12; s_pm = 0;
    void'($urandom(32'd7296));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) cyc(0, 0, 0, 2'(a), 8'h00, "R1");

    // R2 tenths counting and carry into seconds
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 2'd0, 8'h00, "R2");
    cyc(0, 0, 0, 2'd1, 8'h00, "R2");
    cyc(0, 0, 0, 2'd0, 8'h00, "R10");

    // R3 seconds/minutes wrap
    set_time(8'h03, 8'h41, 8'h59, 8'h09, "R3");
    cyc(1, 0, 0, 2'd1, 8'h00, "R3");
    cyc(0, 0, 0, 2'd1, 8'h00, "R3");
    cyc(0, 0, 0, 2'd2, 8'h00, "R3");

    // R4 eleven to twelve flips PM, twelve to one keeps it, nine to ten
    set_time(8'h11, 8'h59, 8'h59, 8'h09, "R4");
    cyc(1, 0, 0, 2'd3, 8'h00, "R4");
    cyc(0, 0, 0, 2'd3, 8'h00, "R4");
    set_time(8'h92, 8'h59, 8'h59, 8'h09, "R4");
    cyc(1, 0, 0, 2'd3, 8'h00, "R4");
    cyc(0, 0, 0, 2'd3, 8'h00, "R4");
    set_time(8'h09, 8'h59, 8'h59, 8'h09, "R4");
    cyc(1, 0, 0, 2'd3, 8'h00, "R4");
    cyc(0, 0, 0, 2'd3, 8'h00, "R4");

    // R5 unused write bits discarded
    set_time(8'hF2, 8'hC7, 8'hD9, 8'hF5, "R5");
    for (int a = 0; a < 4; a++) cyc(0, 0, 0, 2'(a), 8'h00, "R5");

    // R6 freeze on hours read, counting continues, release on tenths read
    cyc(0, 0, 1, 2'd3, 8'h00, "R6");
    for (int i = 0; i < 13; i++) cyc(1, 0, 0, 2'd1, 8'h00, "R6");
    cyc(0, 0, 1, 2'd3, 8'h00, "R6");
    cyc(0, 0, 1, 2'd0, 8'h00, "R6");
    cyc(0, 0, 0, 2'd0, 8'h00, "R6");
    cyc(0, 0, 0, 2'd1, 8'h00, "R6");

    // R7 halt after hours write; restart by tenths write
    cyc(0, 1, 0, 2'd3, 8'h04, "R7");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 2'd0, 8'h00, "R7");
    // R8 mid writes keep halt
    cyc(0, 1, 0, 2'd2, 8'h22, "R8");
    cyc(1, 0, 0, 2'd0, 8'h00, "R8");
    cyc(0, 0, 0, 2'd2, 8'h00, "R8");
    cyc(0, 1, 0, 2'd0, 8'h08, "R7");
    cyc(1, 0, 0, 2'd0, 8'h00, "R7");
    cyc(0, 0, 0, 2'd0, 8'h00, "R7");

    // R9 tick coinciding with write is dropped
    cyc(1, 1, 0, 2'd1, 8'h30, "R9");
    cyc(0, 0, 0, 2'd0, 8'h00, "R9");
    cyc(1, 1, 0, 2'd2, 8'h15, "R9");
    cyc(0, 0, 0, 2'd0, 8'h00, "R9");

    // random mix
    for (int i = 0; i < 20000; i++) begin
      bit tk, wr, rd; logic [1:0] a; logic [7:0] wd; int r; string tag;
      tk = ($urandom % 2) == 0;
      wr = ($urandom % 25) == 0;
      rd = !wr && ($urandom % 6) == 0;
      a  = 2'($urandom % 4);
      r  = $urandom % 4;
      case (a)
        2'd0: wd = to_bcd((r == 0) ? 9 : int'($urandom % 10));
        2'd1, 2'd2: wd = to_bcd((r < 2) ? 59 : int'($urandom % 60));
        default: wd = {1'($urandom % 2), 2'b00,
                       to_bcd((r == 0) ? 11 : (r == 1) ? 12 : 1 + int'($urandom % 12))[4:0]};
      endcase
      if (m_lat) tag = "R6";
      else if (wr) tag = "R8";
      else if (a == 2'd0) tag = "R2";
      else if (a == 2'd3) tag = "R4";
      else tag = "R3";
      cyc(tk, wr, rd, a, wd, tag);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule